// File: doc/BRIEF.md
# Frame Difference Engine

The block walks two frames stored side by side in a shared 32-bit RAM and writes their word-by-word difference into a third region of the same RAM. The RAM has an 18-bit word address. The top two address bits pick one of four equal quadrants, and the low sixteen bits come from an index counter. For every index the engine fetches the word from quadrant 0 and holds it. It then fetches the word at the same index in quadrant 1, subtracts the held value from it, and stores the result in quadrant 2.

A controller sets the number of indices on `span` and raises `go`. Each RAM access is a read or write strobe that stays high until the RAM answers with a one-cycle `mem_ack`. When the index reaches the programmed span, `done` goes high. It stays high until `go` is removed, and the engine then returns to idle. Another rise of `go` starts a fresh pass from index 0.

Top module: `frame_delta_engine`

## Requirements
- R1: While `rst` is high and in the cycle after it is released, `mem_rd`, `mem_wr` and `done` are 0 and `mem_addr` is 0.
- R2: `mem_addr[17:16]` selects the quadrant (00 = first frame, 01 = second frame, 10 = result) and `mem_addr[15:0]` carries the current index.
- R3: For each index the accesses come in this order: read from quadrant 00, then read from quadrant 01, then write to quadrant 10, all at the same index. Indices run upward from 0 in steps of one.
- R4: A read or write strobe, together with its address, is held until `mem_ack` is seen. `mem_rd` and `mem_wr` are never high together.
- R5: The written word equals the quadrant 01 word minus the quadrant 00 word, taken as unsigned values and wrapped modulo 2^32.
- R6: A pass performs exactly `span` index steps. With `span` = 0 the engine makes no RAM access and raises `done`.
- R7: `span` is taken when `go` activates the engine. Later changes to it do not alter the number of steps in the running pass.
- R8: `done` stays high, with no RAM access, for as long as `go` stays high. It falls within two cycles after `go` falls.
- R9: A new activation after a finished pass starts again at index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Activate; held high for the whole pass |
| span | input | 16 | Number of index steps for the pass |
| mem_ack | input | 1 | RAM completion, one cycle per access |
| mem_rdata | input | 32 | RAM read data, valid with `mem_ack` |
| mem_rd | output | 1 | RAM read strobe |
| mem_wr | output | 1 | RAM write strobe |
| mem_addr | output | 18 | RAM word address: quadrant and index |
| mem_wdata | output | 32 | Difference word for writes |
| done | output | 1 | Pass finished |

## Verification
The bench varies the RAM latency from zero to two wait cycles. An engine that drops its strobe early, or that takes data before the acknowledge, would therefore read the wrong word or skip an access. Data pairs where the second word is smaller than the first check the wrap-around: a design that saturated or sign-handled the result would write the wrong word. A zero span and a span change made during a pass are aimed at an engine that tests for the end only after the first step, or that compares against the live input. These would show up as extra or missing accesses. A second pass after `done` catches an index that is not reloaded to 0.

// File: rtl/fde_pkg.sv
package fde_pkg;
    localparam int unsigned IDX_W  = 16;
    localparam int unsigned QSEL_W = 2;
    localparam int unsigned ADDR_W = IDX_W + QSEL_W;
    localparam int unsigned DATA_W = 32;

    typedef enum logic [QSEL_W-1:0] {
        QS_FRAME_A = 2'b00,
        QS_FRAME_B = 2'b01,
        QS_RESULT  = 2'b10,
        QS_SPARE   = 2'b11
    } qsel_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TEST,
        ST_FETCH_A,
        ST_FETCH_B,
        ST_STORE,
        ST_FIN
    } seq_state_e;

    typedef struct packed {
        logic  rd;
        logic  wr;
        logic  clr_idx;
        logic  step_idx;
        logic  hold_a;
        logic  hold_b;
        logic  fin;
        qsel_e qsel;
    } seq_ctl_t;

    function automatic logic [ADDR_W-1:0] join_addr(input qsel_e q, input logic [IDX_W-1:0] i);
        return {q, i};
    endfunction
endpackage

// File: rtl/fde_index.sv
module fde_index
    import fde_pkg::*;
#(
    parameter int unsigned W = IDX_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr_idx,
    input  logic         step_idx,
    input  logic [W-1:0] span,
    output logic [W-1:0] idx,
    output logic         at_end
);
    logic [W-1:0] idx_q;
    logic [W-1:0] span_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q  <= '0;
            span_q <= '0;
        end else if (clr_idx) begin
            idx_q  <= '0;
            span_q <= span;
        end else if (step_idx) begin
            idx_q  <= idx_q + 1'b1;
        end
    end

    assign idx    = idx_q;
    assign at_end = (idx_q == span_q);
endmodule

// File: rtl/fde_datapath.sv
module fde_datapath
    import fde_pkg::*;
#(
    parameter int unsigned W = DATA_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         hold_a,
    input  logic         hold_b,
    input  logic [W-1:0] rdata,
    output logic [W-1:0] diff
);
    logic [W-1:0] a_q;
    logic [W-1:0] diff_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q    <= '0;
            diff_q <= '0;
        end else begin
            if (hold_a) a_q    <= rdata;
            if (hold_b) diff_q <= rdata - a_q;
        end
    end

    assign diff = diff_q;
endmodule

// File: rtl/fde_seq.sv
module fde_seq
    import fde_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     go,
    input  logic     ack,
    input  logic     at_end,
    output seq_ctl_t ctl
);
    seq_state_e st, st_nxt;

    always_ff @(posedge clk) begin
        if (rst) st <= ST_IDLE;
        else     st <= st_nxt;
    end

    always_comb begin
        ctl    = '0;
        st_nxt = st;
        unique case (st)
            ST_IDLE: begin
                if (go) begin
                    ctl.clr_idx = 1'b1;
                    st_nxt      = ST_TEST;
                end
            end
            ST_TEST: begin
                st_nxt = at_end ? ST_FIN : ST_FETCH_A;
            end
            ST_FETCH_A: begin
                ctl.rd   = 1'b1;
                ctl.qsel = QS_FRAME_A;
                if (ack) begin
                    ctl.hold_a = 1'b1;
                    st_nxt     = ST_FETCH_B;
                end
            end
            ST_FETCH_B: begin
                ctl.rd   = 1'b1;
                ctl.qsel = QS_FRAME_B;
                if (ack) begin
                    ctl.hold_b = 1'b1;
                    st_nxt     = ST_STORE;
                end
            end
            ST_STORE: begin
                ctl.wr   = 1'b1;
                ctl.qsel = QS_RESULT;
                if (ack) begin
                    ctl.step_idx = 1'b1;
                    st_nxt       = ST_TEST;
                end
            end
            ST_FIN: begin
                ctl.fin = 1'b1;
                if (!go) st_nxt = ST_IDLE;
            end
            default: st_nxt = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/frame_delta_engine.sv
module frame_delta_engine
    import fde_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic [IDX_W-1:0]  span,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              done
);
    seq_ctl_t         ctl;
    logic [IDX_W-1:0] idx;
    logic             at_end;

    fde_seq u_seq (
        .clk    (clk),
        .rst    (rst),
        .go     (go),
        .ack    (mem_ack),
        .at_end (at_end),
        .ctl    (ctl)
    );

    fde_index #(.W(IDX_W)) u_index (
        .clk      (clk),
        .rst      (rst),
        .clr_idx  (ctl.clr_idx),
        .step_idx (ctl.step_idx),
        .span     (span),
        .idx      (idx),
        .at_end   (at_end)
    );

    fde_datapath #(.W(DATA_W)) u_dp (
        .clk    (clk),
        .rst    (rst),
        .hold_a (ctl.hold_a),
        .hold_b (ctl.hold_b),
        .rdata  (mem_rdata),
        .diff   (mem_wdata)
    );

    assign mem_rd   = ctl.rd;
    assign mem_wr   = ctl.wr;
    assign mem_addr = join_addr(ctl.qsel, idx);
    assign done     = ctl.fin;
endmodule

// File: rtl/frame_delta_engine_chk.sv
module frame_delta_engine_chk
    import fde_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              go,
    input logic              mem_ack,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              done
);
    // R4: read and write strobes are exclusive
    a_r4_strobe_excl: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

    // R4: a read waiting for ack keeps its strobe and address
    a_r4_rd_hold: assert property (@(posedge clk) disable iff (rst)
        (mem_rd && !mem_ack) |=> (mem_rd && $stable(mem_addr)));

    // R4: a write waiting for ack keeps its strobe and address
    a_r4_wr_hold: assert property (@(posedge clk) disable iff (rst)
        (mem_wr && !mem_ack) |=> (mem_wr && $stable(mem_addr)));

    // R2: writes only target the result quadrant
    a_r2_wr_quad: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> (mem_addr[ADDR_W-1:IDX_W] == 2'b10));

    // R2: reads never touch the upper two quadrants
    a_r2_rd_quad: assert property (@(posedge clk) disable iff (rst)
        mem_rd |-> (mem_addr[ADDR_W-1] == 1'b0));

    // R3: a finished first-frame read is followed by the second-frame read at the same index
    a_r3_b_after_a: assert property (@(posedge clk) disable iff (rst)
        (mem_rd && mem_ack && mem_addr[ADDR_W-1:IDX_W] == 2'b00) |=>
        (mem_rd && mem_addr[ADDR_W-1:IDX_W] == 2'b01 &&
         mem_addr[IDX_W-1:0] == $past(mem_addr[IDX_W-1:0])));

    // R3: a finished second-frame read is followed by the result write at the same index
    a_r3_wr_after_b: assert property (@(posedge clk) disable iff (rst)
        (mem_rd && mem_ack && mem_addr[ADDR_W-1:IDX_W] == 2'b01) |=>
        (mem_wr && mem_addr[IDX_W-1:0] == $past(mem_addr[IDX_W-1:0])));

    // R8: done holds while go stays high
    a_r8_done_hold: assert property (@(posedge clk) disable iff (rst)
        (done && go) |=> done);

    // R8: no RAM access while done
    a_r8_done_quiet: assert property (@(posedge clk) disable iff (rst)
        done |-> (!mem_rd && !mem_wr));
endmodule

bind frame_delta_engine frame_delta_engine_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .go       (go),
    .mem_ack  (mem_ack),
    .mem_rd   (mem_rd),
    .mem_wr   (mem_wr),
    .mem_addr (mem_addr),
    .done     (done)
);

// File: tb/sim_frame_delta_engine.sv
`timescale 1ns/1ps
module sim_frame_delta_engine;
    typedef struct packed {
        logic        wr;
        logic [17:0] addr;
        logic [31:0] data;
    } acc_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        go = 1'b0;
    logic [15:0] span = '0;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        mem_rd, mem_wr, done;
    logic [17:0] mem_addr;
    logic [31:0] mem_wdata;

    int   n_chk = 0;
    int   n_bad = 0;
    int   n_acc = 0;
    acc_t expq[$];
    logic [31:0] mem [logic [17:0]];

    always #4 clk = ~clk;

    frame_delta_engine u0 (
        .clk(clk), .rst(rst), .go(go), .span(span),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .done(done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    // RAM model and scoreboard monitor: latency cycles 0..2 by access count
    initial begin
        int          wait_n = 0;
        logic [17:0] start_addr = '0;
        bit          busy = 0;
        forever begin
            @(negedge clk);
            if (mem_ack) begin
                mem_ack = 1'b0;
                busy    = 0;
                wait_n  = 0;
            end else if (mem_rd || mem_wr) begin
                if (!busy) begin
                    busy       = 1;
                    start_addr = mem_addr;
                end
                if (wait_n >= (n_acc % 3)) begin
                    acc_t e;
                    // R4: address held since request began
                    check(mem_addr == start_addr, "R4", "address held to ack",
                          64'(mem_addr), 64'(start_addr));
                    if (expq.size() == 0) begin
                        check(0, "R6", "unexpected access", 64'(mem_addr), 64'h0);
                    end else begin
                        e = expq.pop_front();
                        // R2 R3: kind and address in sequence
                        check(mem_wr == e.wr && mem_addr == e.addr, "R3",
                              "access kind/address", {45'h0, mem_wr, mem_addr},
                              {45'h0, e.wr, e.addr});
                        if (e.wr) begin
                            // R5: difference word
                            check(mem_wdata == e.data, "R5", "written difference",
                                  64'(mem_wdata), 64'(e.data));
                        end
                    end
                    if (mem_wr) mem[mem_addr] = mem_wdata;
                    else        mem_rdata = mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
                    mem_ack = 1'b1;
                    n_acc++;
                end else begin
                    wait_n++;
                end
            end
        end
    end

    task automatic load_pair(input int i, input logic [31:0] a, input logic [31:0] b);
        acc_t e;
        mem[{2'b00, 16'(i)}] = a;
        mem[{2'b01, 16'(i)}] = b;
        e.wr = 0; e.addr = {2'b00, 16'(i)}; e.data = '0; expq.push_back(e);
        e.wr = 0; e.addr = {2'b01, 16'(i)}; e.data = '0; expq.push_back(e);
        e.wr = 1; e.addr = {2'b10, 16'(i)}; e.data = b - a; expq.push_back(e);
    endtask

    task automatic wait_done(input string req);
        bit seen = 0;
        for (int k = 0; k < 3000 && !seen; k++) begin
            @(negedge clk);
            if (done) seen = 1;
        end
        check(seen, req, "done raised", 64'(seen), 64'h1);
        check(expq.size() == 0, req, "all expected accesses seen",
              64'(expq.size()), 64'h0);
    endtask

    task automatic release_go();
        repeat (4) @(negedge clk);
        // R8: done held while go high
        check(done == 1'b1 && !mem_rd && !mem_wr, "R8", "done held, quiet",
              {61'h0, done, mem_rd, mem_wr}, 64'h4);
        go = 1'b0;
        repeat (2) @(negedge clk);
        check(done == 1'b0, "R8", "done dropped after go low", 64'(done), 64'h0);
        @(negedge clk);
    endtask

    task automatic run_pass(input int n, input int seed, input string req);
        for (int i = 0; i < n; i++)
            load_pair(i, 32'(seed * 977 + i * 13), 32'(seed * 31 + i * 1000));
        span = 16'(n);
        go   = 1'b1;
        wait_done(req);
        release_go();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs quiet in reset
        check(!mem_rd && !mem_wr && !done && mem_addr == '0, "R1", "reset outputs",
              {43'h0, mem_rd, mem_wr, done, mem_addr}, 64'h0);
        rst = 1'b0;
        @(negedge clk);
        check(!mem_rd && !mem_wr && !done && mem_addr == '0, "R1", "after reset release",
              {43'h0, mem_rd, mem_wr, done, mem_addr}, 64'h0);

        // R6: zero span makes no access
        span = 16'd0;
        go   = 1'b1;
        wait_done("R6");
        check(n_acc == 0, "R6", "no access with zero span", 64'(n_acc), 64'h0);
        release_go();

        // R3 R5: ordinary pass, ascending indices
        run_pass(5, 3, "R3");

        // R5: wrap-around pairs
        load_pair(0, 32'h0000_0001, 32'h0000_0000);
        load_pair(1, 32'hFFFF_FFFF, 32'h0000_0000);
        load_pair(2, 32'h0000_0000, 32'hFFFF_FFFF);
        load_pair(3, 32'h8000_0000, 32'h7FFF_FFFF);
        span = 16'd4;
        go   = 1'b1;
        wait_done("R5");
        release_go();

        // R7: span changed mid-pass has no effect
        for (int i = 0; i < 3; i++) load_pair(i, 32'(i + 5), 32'(i * 7));
        span = 16'd3;
        go   = 1'b1;
        repeat (4) @(negedge clk);
        span = 16'd9;
        wait_done("R7");
        repeat (6) @(negedge clk);
        check(expq.size() == 0 && done, "R7", "no extra steps after span change",
              64'(expq.size()), 64'h0);
        release_go();

        // R9: new activation restarts at index 0
        run_pass(2, 11, "R9");

        // R6: longer pass, exact count
        run_pass(17, 7, "R6");

        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule